// File: doc/BRIEF.md
# I2C Master Register and Event-Flag Unit

This block is the software-facing register file of an I2C master. A 32-bit bus reaches eight byte-wide registers placed on word boundaries: control, two status registers, clock control, two own-address registers, data, and extended clock control. The serial bus engine and clock divider sit outside. The block hands them the programmed control and clock fields, a transmit byte with a load strobe, and an idle request. It takes back one-cycle event pulses, a few level indications and received bytes.

Event and error pulses are held as flags in the two status registers. A summary event bit in status 1 is set whenever any flag is pending. Each flag is cleared by the access that software makes when it services that flag: a data read or write, a control write, or a status 2 read. A small state machine tracks the peripheral: `ST_OFF` (peripheral enable clear), `ST_QUIET` (enabled, no flag pending) and `ST_PENDING` (enabled, at least one flag pending). The transitions are:
- `ST_OFF` to `ST_QUIET` on a control write with peripheral enable set.
- `ST_QUIET` to `ST_PENDING` when a flag is captured.
- `ST_PENDING` to `ST_QUIET` when the last flag clears.
- `ST_QUIET` or `ST_PENDING` to `ST_OFF` on a control write with peripheral enable clear.

A registered level interrupt is raised from the summary bit and the interrupt-enable bit.

Top module: `i2creg_top`

## Requirements
- R1: The word index `bus_addr[4:2]` selects the register: 0 control, 1 status 1, 2 status 2, 3 clock control, 4 own address 1, 5 own address 2, 6 data, 7 extended clock. A read returns the selected byte copied into all four byte lanes. Addresses with bits above 4 set read as zero.
- R2: A write takes effect only when `bus_wdata[7:0]` equals `bus_wdata[23:16]`. A write whose two halves differ changes no register and has none of the side effects listed in R6, R7 and R9.
- R3: After reset, every register reads 0x00 except own address 2, which reads 0x40. Control bits 7 and 4 always read 0. Own address 2 keeps only bits 7:5 (frequency range) and 2:1 (upper address bits). Extended clock keeps only bits 4:0. Status 2 bit 6 always reads 0.
- R4: While the peripheral is enabled (control bit 5), a pulse on `ev_set` shows in status during the next cycle. The `ev_set` bits map as follows: bit 0 start sent → status 1 bit 0; bit 1 10-bit header → status 1 bit 6; bit 2 byte finished → status 1 bit 3; bit 3 address end → status 2 bit 5; bit 4 stop seen → status 2 bit 3; bit 5 ack failure → status 2 bit 4; bit 6 bus error → status 2 bit 1; bit 7 arbitration lost → status 2 bit 2. While the peripheral is disabled, the pulses are ignored. Status 1 bits 5, 4 and 1 mirror `eng_tx`, `eng_busy` and `eng_master`.
- R5: Status 1 bit 7 is set exactly when at least one flag from R4 is pending.
- R6: A data-register read clears byte-finished. A data-register write clears byte-finished, 10-bit header and start-sent.
- R7: A control write with bit 5 set clears address-end and stop-seen.
- R8: Ack failure, bus error and arbitration lost stay set until status 2 is read while status 1 bit 7 is set, or until the peripheral is disabled.
- R9: A control write with bit 5 clear clears every flag and pulses `idle_req_o` for that cycle.
- R10: `irq_o` is a register that, one cycle later, equals control bit 0 AND status 1 bit 7.
- R11: When an event pulse and the access that clears the same flag fall in the same cycle, the flag ends up set.
- R12: A data write drives `tx_byte_o` with the byte and pulses `tx_load_o` during that cycle. `rx_valid` loads `rx_byte` into the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data; byte duplicated in lanes 0 and 2 |
| bus_rdata | output | 32 | Read data, byte in all four lanes |
| ev_set | input | 8 | Event pulses from the bus engine (order in R4) |
| eng_busy | input | 1 | Bus busy level |
| eng_tx | input | 1 | Transmitter mode level |
| eng_master | input | 1 | Master mode level |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| ctrl_o | output | 8 | Control register contents |
| clk_div_o | output | 12 | Divider: extended bits 4:0 over clock-control bits 6:0 |
| fast_mode_o | output | 1 | Clock-control bit 7 |
| own_addr_o | output | 8 | Own address 1 |
| addr_hi_o | output | 2 | Own address 2 bits 2:1 |
| freq_range_o | output | 3 | Own address 2 bits 7:5 |
| tx_byte_o | output | 8 | Data register contents |
| tx_load_o | output | 1 | Data write strobe |
| idle_req_o | output | 1 | Disable and idle request to the engine |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is combinational. The bench drives a read after a falling edge and samples `bus_rdata` 1 ns later, before the rising edge that applies the read's clearing side effect. Flags set or cleared at rising edge k are visible in the status byte of any read issued after edge k. `irq_o` follows one edge later, at k+1, so the bench checks it both straight after edge k and after edge k+1. `tx_load_o` and `idle_req_o` are sampled in the write cycle itself, before its edge.

// File: rtl/i2creg_pkg.sv
package i2creg_pkg;
    typedef enum logic [2:0] {
        RG_CTRL, RG_STAT1, RG_STAT2, RG_CLK, RG_OWN1, RG_OWN2, RG_DATA, RG_XCLK
    } reg_idx_e;

    localparam int NUM_REGS  = 8;
    localparam int NUM_FLAGS = 8;
    localparam int IDX_LSB   = 2;
    localparam int IDX_W     = 3;

    localparam logic [7:0] CTRL_MASK = 8'h6F;
    localparam logic [7:0] OWN2_MASK = 8'hE6;
    localparam logic [7:0] OWN2_RST  = 8'h40;
    localparam logic [7:0] XCLK_MASK = 8'h1F;

    localparam int CB_IE = 0;
    localparam int CB_PE = 5;

    localparam int FL_SB    = 0;
    localparam int FL_ADD10 = 1;
    localparam int FL_BTF   = 2;
    localparam int FL_ENDAD = 3;
    localparam int FL_STOPF = 4;
    localparam int FL_AF    = 5;
    localparam int FL_BERR  = 6;
    localparam int FL_ARLO  = 7;

    typedef enum logic [1:0] {ST_OFF, ST_QUIET, ST_PENDING} evt_state_e;
endpackage

// File: rtl/i2creg_decode.sv
module i2creg_decode
    import i2creg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [NUM_REGS-1:0] wr_en,
    output logic [NUM_REGS-1:0] rd_en,
    output logic [7:0]          wbyte
);
    localparam int HI_LSB = IDX_LSB + IDX_W;

    logic             halves_ok;
    logic             in_window;
    logic [IDX_W-1:0] idx;
    logic             unused_lanes;

    assign halves_ok    = (bus_wdata[7:0] == bus_wdata[23:16]);
    assign in_window    = (bus_addr[ADDR_W-1:HI_LSB] == '0);
    assign idx          = bus_addr[HI_LSB-1:IDX_LSB];
    assign wbyte        = bus_wdata[7:0];
    assign unused_lanes = ^{bus_addr[IDX_LSB-1:0], bus_wdata[31:24], bus_wdata[15:8]};

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign wr_en[g] = bus_sel &  bus_wr & halves_ok & in_window & (idx == IDX_W'(g));
        assign rd_en[g] = bus_sel & ~bus_wr & in_window & (idx == IDX_W'(g));
    end
endmodule

// File: rtl/i2creg_events.sv
module i2creg_events
    import i2creg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] ev_set,
    input  logic                 pe_q,
    input  logic                 ie_q,
    input  logic                 ctrl_wr,
    input  logic                 ctrl_wpe,
    input  logic                 data_wr,
    input  logic                 data_rd,
    input  logic                 sr2_rd,
    output logic [NUM_FLAGS-1:0] flags_q,
    output logic                 evf,
    output logic                 irq
);
    evt_state_e           state_q, state_n;
    logic [NUM_FLAGS-1:0] clr, flags_n;
    logic                 kill, pe_n;

    assign evf  = (state_q == ST_PENDING);
    assign kill = ctrl_wr & ~ctrl_wpe;
    assign pe_n = ctrl_wr ? ctrl_wpe : pe_q;

    always_comb begin
        clr            = '0;
        clr[FL_SB]     = data_wr;
        clr[FL_ADD10]  = data_wr;
        clr[FL_BTF]    = data_wr | data_rd;
        clr[FL_ENDAD]  = ctrl_wr & ctrl_wpe;
        clr[FL_STOPF]  = ctrl_wr & ctrl_wpe;
        clr[FL_AF]     = sr2_rd & evf;
        clr[FL_BERR]   = sr2_rd & evf;
        clr[FL_ARLO]   = sr2_rd & evf;
        if (kill || !pe_q) flags_n = '0;
        else               flags_n = (flags_q & ~clr) | ev_set;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_OFF:     if (pe_n) state_n = (|flags_n) ? ST_PENDING : ST_QUIET;
            ST_QUIET:   if (kill) state_n = ST_OFF;
                        else if (|flags_n) state_n = ST_PENDING;
            ST_PENDING: if (kill) state_n = ST_OFF;
                        else if (!(|flags_n)) state_n = ST_QUIET;
            default:    state_n = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            flags_q <= '0;
        end else begin
            state_q <= state_n;
            flags_q <= flags_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= ie_q & evf;
    end
endmodule

// File: rtl/i2creg_top.sv
module i2creg_top
    import i2creg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        ev_set,
    input  logic              eng_busy,
    input  logic              eng_tx,
    input  logic              eng_master,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic [7:0]        ctrl_o,
    output logic [11:0]       clk_div_o,
    output logic              fast_mode_o,
    output logic [7:0]        own_addr_o,
    output logic [1:0]        addr_hi_o,
    output logic [2:0]        freq_range_o,
    output logic [7:0]        tx_byte_o,
    output logic              tx_load_o,
    output logic              idle_req_o,
    output logic              irq_o
);
    logic [NUM_REGS-1:0]  wr_en, rd_en;
    logic [7:0]           wbyte, rbyte;
    logic [7:0]           ctrl_q, clk_q, own1_q, own2_q, data_q, xclk_q;
    logic [NUM_FLAGS-1:0] flags_q;
    logic                 evf;
    logic [7:0]           stat1, stat2;

    i2creg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wr_en(wr_en), .rd_en(rd_en), .wbyte(wbyte)
    );

    i2creg_events u_evt (
        .clk(clk), .rst_n(rst_n), .ev_set(ev_set),
        .pe_q(ctrl_q[CB_PE]), .ie_q(ctrl_q[CB_IE]),
        .ctrl_wr(wr_en[RG_CTRL]), .ctrl_wpe(wbyte[CB_PE]),
        .data_wr(wr_en[RG_DATA]), .data_rd(rd_en[RG_DATA]), .sr2_rd(rd_en[RG_STAT2]),
        .flags_q(flags_q), .evf(evf), .irq(irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            clk_q  <= '0;
            own1_q <= '0;
            own2_q <= OWN2_RST;
            xclk_q <= '0;
            data_q <= '0;
        end else begin
            if (wr_en[RG_CTRL]) ctrl_q <= wbyte & CTRL_MASK;
            if (wr_en[RG_CLK])  clk_q  <= wbyte;
            if (wr_en[RG_OWN1]) own1_q <= wbyte;
            if (wr_en[RG_OWN2]) own2_q <= wbyte & OWN2_MASK;
            if (wr_en[RG_XCLK]) xclk_q <= wbyte & XCLK_MASK;
            if (wr_en[RG_DATA]) data_q <= wbyte;
            else if (rx_valid)  data_q <= rx_byte;
        end
    end

    assign stat1 = {evf, flags_q[FL_ADD10], eng_tx, eng_busy,
                    flags_q[FL_BTF], 1'b0, eng_master, flags_q[FL_SB]};
    assign stat2 = {2'b00, flags_q[FL_ENDAD], flags_q[FL_AF], flags_q[FL_STOPF],
                    flags_q[FL_ARLO], flags_q[FL_BERR], 1'b0};

    always_comb begin
        rbyte = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_en[i]) begin
                unique case (reg_idx_e'(i))
                    RG_CTRL:  rbyte = ctrl_q;
                    RG_STAT1: rbyte = stat1;
                    RG_STAT2: rbyte = stat2;
                    RG_CLK:   rbyte = clk_q;
                    RG_OWN1:  rbyte = own1_q;
                    RG_OWN2:  rbyte = own2_q;
                    RG_DATA:  rbyte = data_q;
                    RG_XCLK:  rbyte = xclk_q;
                    default:  rbyte = '0;
                endcase
            end
        end
    end

    assign bus_rdata    = {4{rbyte}};
    assign ctrl_o       = ctrl_q;
    assign clk_div_o    = {xclk_q[4:0], clk_q[6:0]};
    assign fast_mode_o  = clk_q[7];
    assign own_addr_o   = own1_q;
    assign addr_hi_o    = own2_q[2:1];
    assign freq_range_o = own2_q[7:5];
    assign tx_byte_o    = data_q;
    assign tx_load_o    = wr_en[RG_DATA];
    assign idle_req_o   = wr_en[RG_CTRL] & ~wbyte[CB_PE];
endmodule

// File: rtl/i2creg_chk.sv
module i2creg_chk
    import i2creg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [7:0]  ev_set,
    input logic [7:0]  ctrl_o,
    input logic [11:0] clk_div_o,
    input logic [7:0]  own_addr_o,
    input logic        idle_req_o,
    input logic        irq_o,
    input logic [7:0]  flags_q,
    input logic        evf,
    input logic        sr2_rd,
    input logic        ctrl_wr
);
    assert_lane_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:24] == bus_rdata[7:0] && bus_rdata[23:16] == bus_rdata[7:0]
        && bus_rdata[15:8] == bus_rdata[7:0]);

    assert_split_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_wdata[7:0] != bus_wdata[23:16])
        |=> ($stable(ctrl_o) && $stable(own_addr_o) && $stable(clk_div_o)));

    assert_event_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[CB_PE] && ev_set[FL_SB] && !idle_req_o) |=> flags_q[FL_SB]);

    assert_summary_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evf == (|flags_q));

    assert_error_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[FL_AF] && !sr2_rd && !ctrl_wr) |=> flags_q[FL_AF]);

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req_o |=> (flags_q == '0 && !evf));

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(ctrl_o[CB_IE] && evf));
endmodule

bind i2creg_top i2creg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_set(ev_set),
    .ctrl_o(ctrl_o), .clk_div_o(clk_div_o), .own_addr_o(own_addr_o),
    .idle_req_o(idle_req_o), .irq_o(irq_o), .flags_q(flags_q), .evf(evf),
    .sr2_rd(rd_en[i2creg_pkg::RG_STAT2]), .ctrl_wr(wr_en[i2creg_pkg::RG_CTRL])
);

// File: tb/i2creg_tb.sv
`timescale 1ns/1ps
module i2creg_top_tb_top;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [7:0]        ev_set = '0;
    logic              eng_busy = 1'b0, eng_tx = 1'b0, eng_master = 1'b0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_byte = '0;
    logic [7:0]        ctrl_o, own_addr_o, tx_byte_o;
    logic [11:0]       clk_div_o;
    logic              fast_mode_o, tx_load_o, idle_req_o, irq_o;
    logic [1:0]        addr_hi_o;
    logic [2:0]        freq_range_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    logic [7:0] rd;
    logic       got_load, got_idle;

    always #2.5 clk = ~clk;

    i2creg_top #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_set(ev_set), .eng_busy(eng_busy), .eng_tx(eng_tx), .eng_master(eng_master),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .ctrl_o(ctrl_o), .clk_div_o(clk_div_o),
        .fast_mode_o(fast_mode_o), .own_addr_o(own_addr_o), .addr_hi_o(addr_hi_o),
        .freq_range_o(freq_range_o), .tx_byte_o(tx_byte_o), .tx_load_o(tx_load_o),
        .idle_req_o(idle_req_o), .irq_o(irq_o)
    );

    // offset, written byte, expected readback
    localparam logic [23:0] VEC [0:6] = '{
        24'h0C_A5_A5, 24'h10_3C_3C, 24'h14_FF_E6, 24'h1C_FF_1F,
        24'h18_5A_5A, 24'h00_FF_6F, 24'h00_00_00
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic rd_reg(input logic [7:0] off, output logic [7:0] val);
        logic [31:0] w;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = off;
        #1 w = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
        chk("R1 lane copy", w, {4{w[7:0]}});
        val = w[7:0];
    endtask

    task automatic wr_raw(input logic [7:0] off, input logic [31:0] w);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = off; bus_wdata = w;
        #1 got_load = tx_load_o; got_idle = idle_req_o;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] off, input logic [7:0] b);
        wr_raw(off, {8'h00, b, 8'h00, b});
    endtask

    task automatic pulse(input logic [7:0] v);
        @(negedge clk);
        ev_set = v;
        @(posedge clk);
        #1 ev_set = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R3 reset values
        rd_reg(8'h00, rd); chk("R3 ctrl reset", rd, 8'h00);
        rd_reg(8'h14, rd); chk("R3 own2 reset", rd, 8'h40);
        rd_reg(8'h04, rd); chk("R3 stat1 reset", rd, 8'h00);
        rd_reg(8'h08, rd); chk("R3 stat2 reset", rd, 8'h00);
        chk("R3 irq reset", irq_o, 0);
        chk("R3 range field", freq_range_o, 3'd2);

        // R1 R3 table walk
        for (int i = 0; i < 7; i++) begin
            wr_reg(VEC[i][23:16], VEC[i][15:8]);
            rd_reg(VEC[i][23:16], rd);
            chk("R1 R3 table readback", rd, VEC[i][7:0]);
        end
        chk("R3 divider field", clk_div_o, {5'h1F, 7'h25});
        rd_reg(8'h3C, rd); chk("R1 out of window", rd, 8'h00);

        // R2 split write
        wr_raw(8'h10, 32'h0011_0022);
        rd_reg(8'h10, rd); chk("R2 split write ignored", rd, 8'h3C);

        // R4 R5 R10 start event with interrupt
        wr_reg(8'h00, 8'h21);
        pulse(8'h01);
        chk("R10 irq not yet", irq_o, 0);
        @(posedge clk); #1 chk("R10 irq raised", irq_o, 1);
        rd_reg(8'h04, rd); chk("R4 R5 start flag", rd, 8'h81);
        // R2 split control write must not disable
        wr_raw(8'h00, 32'h0000_0011);
        chk("R2 no idle pulse", got_idle, 0);
        rd_reg(8'h04, rd); chk("R2 flag kept", rd, 8'h81);
        // R6 R12 data write clears start
        wr_reg(8'h18, 8'h77);
        chk("R12 tx load", got_load, 1);
        chk("R12 tx byte", tx_byte_o, 8'h77);
        chk("R10 irq lags", irq_o, 1);
        @(posedge clk); #1 chk("R10 irq drops", irq_o, 0);
        rd_reg(8'h04, rd); chk("R6 start cleared", rd, 8'h00);

        // R4 R6 byte finished with engine levels
        eng_tx = 1'b1; eng_busy = 1'b1; eng_master = 1'b1;
        pulse(8'h04);
        rd_reg(8'h04, rd); chk("R4 btf and levels", rd, 8'hBA);
        rd_reg(8'h18, rd);
        rd_reg(8'h04, rd); chk("R6 data read clears btf", rd, 8'h32);
        eng_tx = 1'b0; eng_busy = 1'b0; eng_master = 1'b0;

        // R12 receive
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'hC3;
        @(posedge clk); #1 rx_valid = 1'b0;
        rd_reg(8'h18, rd); chk("R12 rx load", rd, 8'hC3);

        // R6 header flag
        pulse(8'h02);
        rd_reg(8'h04, rd); chk("R4 header flag", rd, 8'hC0);
        wr_reg(8'h18, 8'h00);
        rd_reg(8'h04, rd); chk("R6 header cleared", rd, 8'h00);

        // R7 address end and stop
        pulse(8'h18);
        rd_reg(8'h08, rd); chk("R4 endad stop", rd, 8'h28);
        wr_reg(8'h00, 8'h20);
        rd_reg(8'h08, rd); chk("R7 cleared by control", rd, 8'h00);
        rd_reg(8'h04, rd); chk("R5 summary clear", rd, 8'h00);

        // R8 sticky errors; R10 irq off when disabled by IE
        pulse(8'h20);
        wr_reg(8'h00, 8'h20);
        rd_reg(8'h18, rd);
        @(posedge clk); #1 chk("R10 irq masked", irq_o, 0);
        rd_reg(8'h08, rd); chk("R8 ack fail held", rd, 8'h10);
        rd_reg(8'h08, rd); chk("R8 cleared by stat2 read", rd, 8'h00);
        pulse(8'hC0);
        rd_reg(8'h08, rd); chk("R4 berr arlo", rd, 8'h06);
        rd_reg(8'h08, rd); chk("R8 berr arlo cleared", rd, 8'h00);

        // R9 disable
        pulse(8'h21);
        wr_reg(8'h00, 8'h00);
        chk("R9 idle pulse", got_idle, 1);
        rd_reg(8'h04, rd); chk("R9 stat1 cleared", rd, 8'h00);
        rd_reg(8'h08, rd); chk("R9 stat2 cleared", rd, 8'h00);
        pulse(8'h01);
        rd_reg(8'h04, rd); chk("R4 ignored while off", rd, 8'h00);

        // R11 set beats clear
        wr_reg(8'h00, 8'h20);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h18; ev_set = 8'h04;
        @(posedge clk);
        #1 bus_sel = 1'b0; ev_set = '0;
        rd_reg(8'h04, rd); chk("R11 set wins", rd, 8'h88);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule